// File: doc/BRIEF.md
# LCD Controller Command Sequencer

This block brings up and manages a 128x64 monochrome LCD controller over a byte-wide command port. It issues a byte with a command/data select line and a chip-select line. Each byte is handed to a downstream serial shifter through a valid/ready handshake. A host starts one of four jobs with a single-cycle request pulse: power-up, sleep-enter, sleep-exit and contrast update. The block then runs that job's fixed script to the end on its own. `busy_o` is high while a job runs, and `done_o` pulses once when the job completes.

The power-up job drives the panel's active-low reset for a fixed time. It then sends the panel settings and turns on the three power stages in order, with a wait after each stage. It sets contrast and switches the display on. As a self-test it lights every pixel briefly, then returns to normal display. All waits are counted in milliseconds, derived from the parameter `CYC_PER_MS` (clock cycles per millisecond). The script steps are stored as a compact step table: chip-select change, literal byte, contrast argument, reset pulse, wait, end. A single program counter walks this table.

Top module: `lcd_cmd_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `cmd_valid_o` and `cs_o` are 0 and `lcd_rst_no` is 1.
- R2: The power-up job sends exactly these bytes in order: A2, A0, C8, 40, 2C, 2E, 2F, 10, A6, 81, 1E, AF, A5, A4 (hex).
- R3: During power-up, before the first byte, `lcd_rst_no` is low for exactly 242 ms (242*CYC_PER_MS cycles). It is low only while a job is running.
- R4: With `cmd_ready_i` held high, the accept of 2E, of 2F and of 10 each comes 50*CYC_PER_MS+1 cycles after the accept of the byte before it. A5 comes 100*CYC_PER_MS+1 cycles after AF. A4 comes 200*CYC_PER_MS+1 cycles after A5.
- R5: A byte counts as sent only in a cycle where `cmd_valid_o` and `cmd_ready_i` are both high. While it is stalled, `cmd_valid_o` stays high and `cmd_byte_o` stays unchanged.
- R6: Every byte is sent with `cmd_dc_o` = 0 (instruction mode) and `cs_o` = 1.
- R7: A contrast job sends 81 and then the requested 8-bit value shifted right by two. The value is captured when the request is taken.
- R8: A sleep-enter job sends AC, 00, AE, A5. A sleep-exit job sends A4, AF and raises `done_o` 50*CYC_PER_MS+2 cycles after the AF accept.
- R9: A request that arrives while `busy_o` is high is dropped. It adds no bytes and no `done_o` pulse.
- R10: When several requests arrive in the same idle cycle, only one job runs. The order of precedence is power-up, then sleep-exit, then sleep-enter, then contrast.
- R11: `done_o` is high for exactly one cycle per job, and `busy_o` is already low in that cycle.
- R12: `cs_o` is 0 whenever no job is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_init_i | input | 1 | Power-up job request pulse |
| req_sleep_i | input | 1 | Sleep-enter job request pulse |
| req_wake_i | input | 1 | Sleep-exit job request pulse |
| req_contrast_i | input | 1 | Contrast job request pulse |
| contrast_i | input | 8 | Contrast value, captured with the request |
| busy_o | output | 1 | A job is running |
| done_o | output | 1 | One-cycle pulse at job completion |
| cmd_byte_o | output | 8 | Byte to send |
| cmd_dc_o | output | 1 | Command/data select (0 = instruction) |
| cmd_valid_o | output | 1 | Byte valid toward the shifter |
| cmd_ready_i | input | 1 | Shifter accepts the byte |
| cs_o | output | 1 | Panel chip select (1 = selected) |
| lcd_rst_no | output | 1 | Panel reset, active low |

## Verification
Two events can fall in the same cycle. One is a new request arriving while a job is running. The other is several requests arriving together in one idle cycle, which the arbiter must resolve. The bench pulses a sleep-enter request partway through power-up and checks that the power-up byte list and the single done pulse are unchanged. It then pulses sleep-exit, sleep-enter and contrast together, and later sleep-enter and contrast together. Each time it checks that only the byte list of the job with higher precedence appears. Randomised jobs with a stuttering ready signal confirm that stalls never change the byte order or the bytes themselves.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [2:0] {
    OP_CS, OP_BYTE, OP_ARG, OP_RST, OP_WAIT, OP_END
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] arg;
  } step_t;

  localparam int PC_W = 6;
  localparam int N_REQ = 4;
  // request index = precedence (0 wins)
  localparam int RQ_INIT = 0;
  localparam int RQ_WAKE = 1;
  localparam int RQ_SLEEP = 2;
  localparam int RQ_CONTRAST = 3;

  localparam logic [PC_W-1:0] PC_INIT     = 6'd0;
  localparam logic [PC_W-1:0] PC_SLEEP    = 6'd23;
  localparam logic [PC_W-1:0] PC_WAKE     = 6'd29;
  localparam logic [PC_W-1:0] PC_CONTRAST = 6'd34;
endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
  import lcd_seq_pkg::*;
(
  input  logic [PC_W-1:0] pc_i,
  output step_t           step_o
);
  function automatic step_t mk(op_e op, logic [7:0] a);
    step_t s;
    s.op  = op;
    s.arg = a;
    return s;
  endfunction

  always_comb begin
    unique case (pc_i)
      // power-up
      6'd0:  step_o = mk(OP_CS,   8'd0);
      6'd1:  step_o = mk(OP_CS,   8'd1);
      6'd2:  step_o = mk(OP_RST,  8'd242);
      6'd3:  step_o = mk(OP_BYTE, 8'hA2);
      6'd4:  step_o = mk(OP_BYTE, 8'hA0);
      6'd5:  step_o = mk(OP_BYTE, 8'hC8);
      6'd6:  step_o = mk(OP_BYTE, 8'h40);
      6'd7:  step_o = mk(OP_BYTE, 8'h2C);
      6'd8:  step_o = mk(OP_WAIT, 8'd50);
      6'd9:  step_o = mk(OP_BYTE, 8'h2E);
      6'd10: step_o = mk(OP_WAIT, 8'd50);
      6'd11: step_o = mk(OP_BYTE, 8'h2F);
      6'd12: step_o = mk(OP_WAIT, 8'd50);
      6'd13: step_o = mk(OP_BYTE, 8'h10);
      6'd14: step_o = mk(OP_BYTE, 8'hA6);
      6'd15: step_o = mk(OP_BYTE, 8'h81);
      6'd16: step_o = mk(OP_BYTE, 8'h1E);
      6'd17: step_o = mk(OP_BYTE, 8'hAF);
      6'd18: step_o = mk(OP_WAIT, 8'd100);
      6'd19: step_o = mk(OP_BYTE, 8'hA5);
      6'd20: step_o = mk(OP_WAIT, 8'd200);
      6'd21: step_o = mk(OP_BYTE, 8'hA4);
      6'd22: step_o = mk(OP_END,  8'd0);
      // sleep-enter
      6'd23: step_o = mk(OP_CS,   8'd1);
      6'd24: step_o = mk(OP_BYTE, 8'hAC);
      6'd25: step_o = mk(OP_BYTE, 8'h00);
      6'd26: step_o = mk(OP_BYTE, 8'hAE);
      6'd27: step_o = mk(OP_BYTE, 8'hA5);
      6'd28: step_o = mk(OP_END,  8'd0);
      // sleep-exit
      6'd29: step_o = mk(OP_CS,   8'd1);
      6'd30: step_o = mk(OP_BYTE, 8'hA4);
      6'd31: step_o = mk(OP_BYTE, 8'hAF);
      6'd32: step_o = mk(OP_WAIT, 8'd50);
      6'd33: step_o = mk(OP_END,  8'd0);
      // contrast
      6'd34: step_o = mk(OP_CS,   8'd1);
      6'd35: step_o = mk(OP_BYTE, 8'h81);
      6'd36: step_o = mk(OP_ARG,  8'd0);
      6'd37: step_o = mk(OP_END,  8'd0);
      default: step_o = mk(OP_END, 8'd0);
    endcase
  end
endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CYC_PER_MS = 16000,
  parameter int MS_W       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);
  localparam int CYC_W = $clog2(CYC_PER_MS + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [MS_W-1:0]  ms_q;
  logic             cyc_wrap;

  assign cyc_wrap = (cyc_q == CYC_LAST);
  assign done_o   = run_i && ((ms_i == '0) || (cyc_wrap && (ms_q == ms_i - 1'b1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (!run_i || done_o) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (cyc_wrap) begin
      cyc_q <= '0;
      ms_q  <= ms_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R4: the cycle counter never passes one millisecond
  p_cyc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= CYC_LAST);
  // R4: the millisecond counter stays below the requested wait
  p_ms_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && ms_i != '0 |-> ms_q < ms_i);
endmodule

// File: rtl/lcd_req_arb.sv
module lcd_req_arb
  import lcd_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [N_REQ-1:0] req_i,
  output logic             start_o,
  output logic             take_contrast_o,
  output logic [PC_W-1:0]  start_pc_o
);
  logic [N_REQ-1:0] gnt;

  // lowest index wins
  always_comb begin
    gnt = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) gnt = N_REQ'(1) << i;
    end
    if (!idle_i) gnt = '0;
  end

  always_comb begin
    start_pc_o = PC_INIT;
    if (gnt[RQ_WAKE])     start_pc_o = PC_WAKE;
    if (gnt[RQ_SLEEP])    start_pc_o = PC_SLEEP;
    if (gnt[RQ_CONTRAST]) start_pc_o = PC_CONTRAST;
  end

  assign start_o         = |gnt;
  assign take_contrast_o = gnt[RQ_CONTRAST];

  // R10: at most one job granted per cycle
  p_one_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));
  // R9: nothing granted while a job runs
  p_no_grant_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !start_o);
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int CYC_PER_MS = 16000,
  parameter int MS_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_init_i,
  input  logic       req_sleep_i,
  input  logic       req_wake_i,
  input  logic       req_contrast_i,
  input  logic [7:0] contrast_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] cmd_byte_o,
  output logic       cmd_dc_o,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic       cs_o,
  output logic       lcd_rst_no
);
  logic [PC_W-1:0]  pc_q;
  logic             busy_q, cs_q, done_q;
  logic [7:0]       cval_q;
  step_t            step;
  logic [N_REQ-1:0] req;
  logic             start, take_contrast, tmr_run, tmr_done, sending;
  logic [PC_W-1:0]  start_pc;

  always_comb begin
    req = '0;
    req[RQ_INIT]     = req_init_i;
    req[RQ_WAKE]     = req_wake_i;
    req[RQ_SLEEP]    = req_sleep_i;
    req[RQ_CONTRAST] = req_contrast_i;
  end

  lcd_req_arb u_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .idle_i          (!busy_q),
    .req_i           (req),
    .start_o         (start),
    .take_contrast_o (take_contrast),
    .start_pc_o      (start_pc)
  );

  lcd_seq_rom u_rom (
    .pc_i   (pc_q),
    .step_o (step)
  );

  assign tmr_run = busy_q && (step.op == OP_WAIT || step.op == OP_RST);

  lcd_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .ms_i   (MS_W'(step.arg)),
    .done_o (tmr_done)
  );

  assign sending = busy_q && (step.op == OP_BYTE || step.op == OP_ARG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      cs_q   <= 1'b0;
      done_q <= 1'b0;
      cval_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          pc_q   <= start_pc;
        end
        if (take_contrast) cval_q <= contrast_i;
      end else begin
        unique case (step.op)
          OP_CS: begin
            cs_q <= step.arg[0];
            pc_q <= pc_q + 1'b1;
          end
          OP_BYTE, OP_ARG: if (cmd_ready_i) pc_q <= pc_q + 1'b1;
          OP_RST, OP_WAIT: if (tmr_done) pc_q <= pc_q + 1'b1;
          default: begin
            cs_q   <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign cs_o        = cs_q;
  assign cmd_dc_o    = 1'b0;
  assign cmd_valid_o = sending;
  assign cmd_byte_o  = (step.op == OP_ARG) ? (cval_q >> 2) : step.arg;
  assign lcd_rst_no  = !(busy_q && step.op == OP_RST);

  // R5: a stalled byte stays offered and unchanged
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_byte_o));
  // R6: bytes go out in instruction mode with the panel selected
  p_cmd_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !cmd_dc_o && cs_o);
  // R3: reset pulse only inside a job
  p_rst_in_job_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_rst_no |-> busy_o);
  // R11: single-cycle done, already idle
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R12: panel deselected when idle
  p_cs_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cs_o);
endmodule

// File: tb/tb_lcd_cmd_seq.sv
`timescale 1ns/1ps
module tb_lcd_cmd_seq;
  localparam int C = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_init = 0, req_sleep = 0, req_wake = 0, req_contrast = 0;
  logic [7:0] contrast = 0;
  logic busy, done, dc, valid, cs, lcd_rst_n;
  logic [7:0] cmd;
  logic ready = 1'b1;

  always #2.5 clk = ~clk;

  lcd_cmd_seq #(.CYC_PER_MS(C)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_init_i(req_init), .req_sleep_i(req_sleep), .req_wake_i(req_wake),
    .req_contrast_i(req_contrast), .contrast_i(contrast),
    .busy_o(busy), .done_o(done), .cmd_byte_o(cmd), .cmd_dc_o(dc),
    .cmd_valid_o(valid), .cmd_ready_i(ready), .cs_o(cs), .lcd_rst_no(lcd_rst_n)
  );

  int errors = 0, checks = 0;
  int cyc = 0, done_cnt = 0, done_cyc = 0, rst_low = 0, hold_err = 0, mode_err = 0;
  bit rnd_ready = 0, prev_stall = 0;
  logic [7:0] prev_byte;
  logic [7:0] got_q[$];
  int got_t[$];
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive ready, then sample what the next edge will see
  always @(negedge clk) begin
    cyc++;
    ready = rnd_ready ? (($urandom % 10) < 7) : 1'b1;
    #1;
    if (rst_n) begin
      if (prev_stall && !(valid && cmd == prev_byte)) hold_err++;
      prev_stall = valid && !ready;
      prev_byte  = cmd;
      if (valid && ready) begin
        got_q.push_back(cmd);
        got_t.push_back(cyc);
        if (dc || !cs) mode_err++;
      end
      if (!lcd_rst_n) rst_low++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic void build(int kind, logic [7:0] v);
    exp_q = {};
    case (kind)
      0: exp_q = '{8'hA2, 8'hA0, 8'hC8, 8'h40, 8'h2C, 8'h2E, 8'h2F,
                   8'h10, 8'hA6, 8'h81, 8'h1E, 8'hAF, 8'hA5, 8'hA4};
      1: exp_q = '{8'hA4, 8'hAF};
      2: exp_q = '{8'hAC, 8'h00, 8'hAE, 8'hA5};
      default: exp_q = '{8'h81, v >> 2};
    endcase
  endfunction

  // mask bit0 init, bit1 wake, bit2 sleep, bit3 contrast
  task automatic pulse(logic [3:0] m, logic [7:0] v);
    @(negedge clk);
    req_init = m[0]; req_wake = m[1]; req_sleep = m[2]; req_contrast = m[3];
    contrast = v;
    @(negedge clk);
    req_init = 0; req_wake = 0; req_sleep = 0; req_contrast = 0;
    contrast = 8'h00;
  endtask

  task automatic wait_done(int d0);
    while (done_cnt == d0) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic compare(string req);
    bit ok = (got_q.size() == exp_q.size());
    chk(ok, {req, " length"}, got_q.size(), exp_q.size());
    if (ok) foreach (exp_q[i]) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
  endtask

  task automatic job(logic [3:0] m, logic [7:0] v, int kind, string req);
    int d0 = done_cnt;
    got_q = {}; got_t = {};
    pulse(m, v);
    wait_done(d0);
    // done seen: busy already low, cs released
    chk(!busy, "R11 busy at done", busy, 0);
    chk(!cs, "R12 cs idle", cs, 0);
    @(negedge clk); #2;
    chk(!done, "R11 done width", done, 0);
    build(kind, v);
    compare(req);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !done && !valid && !cs && lcd_rst_n, "R1 reset state",
        {busy, done, valid, cs, lcd_rst_n}, 5'b00001);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // power-up with ready high, plus a sleep request mid-run
    begin
      int d0 = done_cnt;
      got_q = {}; got_t = {};
      rst_low = 0;
      pulse(4'b0001, 8'h00);
      repeat (40) @(negedge clk);
      pulse(4'b0100, 8'h00);   // R9: dropped
      wait_done(d0);
      chk(!busy, "R11 busy at done", busy, 0);
      build(0, 8'h00);
      compare("R2 power-up bytes");
      chk(rst_low == 242 * C, "R3 reset width", rst_low, 242 * C);
      if (got_t.size() == 14) begin
        chk(got_t[1] - got_t[0] == 1, "R4 back-to-back", got_t[1] - got_t[0], 1);
        for (int i = 5; i <= 7; i++)
          chk(got_t[i] - got_t[i-1] == 50 * C + 1, "R4 stage wait",
              got_t[i] - got_t[i-1], 50 * C + 1);
        chk(got_t[12] - got_t[11] == 100 * C + 1, "R4 wait before A5",
            got_t[12] - got_t[11], 100 * C + 1);
        chk(got_t[13] - got_t[12] == 200 * C + 1, "R4 wait after A5",
            got_t[13] - got_t[12], 200 * C + 1);
      end
      repeat (30) @(negedge clk);
      #2;
      chk(done_cnt == d0 + 1, "R9 dropped request done count", done_cnt, d0 + 1);
      chk(got_q.size() == 14, "R9 dropped request bytes", got_q.size(), 14);
    end

    // sleep-exit timing to done
    job(4'b0010, 8'h00, 1, "R8 sleep-exit bytes");
    if (got_t.size() == 2)
      chk(done_cyc - got_t[1] == 50 * C + 2, "R8 sleep-exit wait",
          done_cyc - got_t[1], 50 * C + 2);

    // simultaneous requests
    job(4'b1110, 8'hFF, 1, "R10 wake over sleep and contrast");
    job(4'b1100, 8'h80, 2, "R10 sleep over contrast");
    job(4'b1000, 8'hFF, 3, "R7 contrast max");
    job(4'b1000, 8'h03, 3, "R7 contrast low bits");

    // random jobs with stuttering ready
    rnd_ready = 1;
    for (int n = 0; n < 24; n++) begin
      int k = 1 + ($urandom % 3);
      logic [7:0] v = 8'($urandom);
      logic [3:0] m = (k == 1) ? 4'b0010 : (k == 2) ? 4'b0100 : 4'b1000;
      job(m, v, k, (k == 3) ? "R7 random contrast" : "R8 random sleep job");
    end
    rnd_ready = 0;
    @(negedge clk); #2;

    chk(hold_err == 0, "R5 stall hold", hold_err, 0);
    chk(mode_err == 0, "R6 instruction mode and select", mode_err, 0);
    chk(lcd_rst_n, "R3 reset idle high", lcd_rst_n, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule